// File: doc/BRIEF.md
# Base-Bounds Address Translator

This block turns a 32-bit virtual address into a physical address without a page table or translation lookaside buffer. The address space is cut into eight 512 MB regions, selected by the top three address bits. The lower half (regions 0 to 3) is the user segment. It may be reached from either privilege level and is relocated. A limit register checks the address, and then a base register is added to it. Instruction fetches use one base/limit pair and loads/stores use a second pair. The upper half is reserved for kernel mode. Region 4 (cached) and region 5 (uncached) map straight to the bottom 512 MB of physical memory. Regions 6 and 7 pass the address through unchanged.

Alongside the physical address the unit reports a 3-bit cache policy code. The code is read from a per-region field of an attribute register. The unit also raises a fault flag for an out-of-limit user access or for a kernel-only region reached from user mode. The translation path is purely combinational. The five configuration registers are loaded through a simple write port, and a write takes effect from the clock edge that captures it.

Top module: `bb_xlate_top`

## Requirements
- R1: After reset every base and limit register and the attribute register read as zero. In user mode a data access to 0x00000000 translates to 0x00000000 with code 0 and no fault, and an address of 0x00000004 faults.
- R2: An instruction fetch (accFetch=1) to a user-segment address (bit 31 = 0) that is in range yields the address plus the instruction base, modulo 2^32.
- R3: A load/store (accFetch=0) to the user segment is checked and relocated with the data limit and data base only, independently of the instruction pair.
- R4: A user-segment address is in range when it is less than or equal to the selected limit. One above the limit raises addrFault.
- R5: A user-mode access to any address with bit 31 set raises addrFault. In kernel mode, user-segment addresses are still limit-checked and relocated.
- R6: In kernel mode, regions 4 and 5 (0x80000000 to 0xBFFFFFFF) translate by clearing address bits 31..29, and ignore the base and limit registers.
- R7: In kernel mode, regions 6 and 7 (0xC0000000 to 0xFFFFFFFF) translate to the unchanged virtual address.
- R8: The cache code for a non-faulting access is attribute register bits [3r+2:3r], where r is virtual address bits 31..29. Code 0 means uncached.
- R9: Region 5 always reports code 0, whatever its attribute field holds.
- R10: While addrFault is high, paddr and cacheAttr are zero and badVaddr equals vaddr. Otherwise badVaddr is zero.
- R11: Write select codes are 0 instruction base, 1 instruction limit, 2 data base, 3 data limit, 4 attribute register (bits 23..0 of the data). A write is visible from the edge that captures it. Select codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vaddr | input | 32 | Virtual address to translate |
| accFetch | input | 1 | 1 = instruction fetch, 0 = load/store |
| kernelMode | input | 1 | 1 = kernel privilege, 0 = user |
| regWrEn | input | 1 | Configuration write strobe |
| regWrSel | input | 3 | Configuration register select |
| regWrData | input | 32 | Configuration write data |
| paddr | output | 32 | Physical address |
| cacheAttr | output | 3 | Cache policy code for the access |
| addrFault | output | 1 | Address exception flag |
| badVaddr | output | 32 | Faulting virtual address, else zero |

## Verification
All translation state lives in five registers, and none of them is visible directly. A corrupted base therefore shows up as a wrong paddr on the first in-range access that uses that pair. A corrupted limit shows up as a wrong addrFault only when an address falls between the true limit and the stored one, so the bench probes both sides of each limit. A bad attribute field shows up only for accesses to that region. The bench therefore touches every region after loading a distinct code into each field. It also places a write in the same cycle as a lookup, to show that the new value appears right after the capturing edge and not one cycle later.

// File: rtl/bb_xlate_pkg.sv
`timescale 1ns/1ps
package bb_xlate_pkg;

  localparam int ATTR_W = 3;
  localparam logic [ATTR_W-1:0] ATTR_UNCACHED = '0;

  typedef enum logic [2:0] {
    SEL_IBASE  = 3'd0,
    SEL_IBOUND = 3'd1,
    SEL_DBASE  = 3'd2,
    SEL_DBOUND = 3'd3,
    SEL_ATTR   = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrIBase;
    logic wrIBound;
    logic wrDBase;
    logic wrDBound;
    logic wrAttr;
    logic useInst;     // pick instruction pair
    logic relocate;    // user segment: limit check + base add
    logic fixedClear;  // direct-mapped kernel window
    logic forceUnc;    // uncached kernel window
    logic privFault;   // kernel-only region from user mode
  } xlateStrb_t;

endpackage

// File: rtl/bb_xlate_ctrl.sv
`timescale 1ns/1ps
module bb_xlate_ctrl
  import bb_xlate_pkg::*;
#(
  parameter int RB = 3
) (
  input  logic [RB-1:0] region,
  input  logic          kernelMode,
  input  logic          accFetch,
  input  logic          regWrEn,
  input  logic [2:0]    regWrSel,
  output xlateStrb_t    strb
);

  localparam int NR = 1 << RB;
  localparam logic [RB-1:0] RGN_KCACHED   = RB'(NR / 2);
  localparam logic [RB-1:0] RGN_KUNCACHED = RB'(NR / 2 + 1);

  logic userSeg;
  assign userSeg = ~region[RB-1];

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regSel_e'(regWrSel))
        SEL_IBASE:  strb.wrIBase  = 1'b1;
        SEL_IBOUND: strb.wrIBound = 1'b1;
        SEL_DBASE:  strb.wrDBase  = 1'b1;
        SEL_DBOUND: strb.wrDBound = 1'b1;
        SEL_ATTR:   strb.wrAttr   = 1'b1;
        default:    ;
      endcase
    end
    strb.useInst    = accFetch;
    strb.relocate   = userSeg;
    strb.fixedClear = (region == RGN_KCACHED) || (region == RGN_KUNCACHED);
    strb.forceUnc   = (region == RGN_KUNCACHED);
    strb.privFault  = ~userSeg & ~kernelMode;
  end

endmodule

// File: rtl/bb_xlate_datapath.sv
`timescale 1ns/1ps
module bb_xlate_datapath
  import bb_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int RB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrb_t        strb,
  input  logic [AW-1:0]     regWrData,
  input  logic [AW-1:0]     vaddr,
  output logic [AW-1:0]     paddr,
  output logic [ATTR_W-1:0] cacheAttr,
  output logic              addrFault,
  output logic [AW-1:0]     badVaddr
);

  localparam int NR    = 1 << RB;
  localparam int AR_W  = NR * ATTR_W;
  localparam int LOW_W = AW - RB;

  logic [AW-1:0]   iBase, iBound, dBase, dBound;
  logic [AR_W-1:0] attrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iBase   <= '0;
      iBound  <= '0;
      dBase   <= '0;
      dBound  <= '0;
      attrReg <= '0;
    end else begin
      if (strb.wrIBase)  iBase   <= regWrData;
      if (strb.wrIBound) iBound  <= regWrData;
      if (strb.wrDBase)  dBase   <= regWrData;
      if (strb.wrDBound) dBound  <= regWrData;
      if (strb.wrAttr)   attrReg <= regWrData[AR_W-1:0];
    end
  end

  // per-region attribute fields
  logic [ATTR_W-1:0] fieldArr [NR];
  for (genvar g = 0; g < NR; g++) begin : g_field
    assign fieldArr[g] = attrReg[g*ATTR_W +: ATTR_W];
  end

  logic [RB-1:0] region;
  logic [AW-1:0] selBound, selBase, relocSum, fixedAddr;
  logic          inBounds, fault;

  assign region    = vaddr[AW-1 -: RB];
  assign selBound  = strb.useInst ? iBound : dBound;
  assign selBase   = strb.useInst ? iBase  : dBase;
  assign inBounds  = (vaddr <= selBound);
  assign relocSum  = vaddr + selBase;
  assign fixedAddr = {{RB{1'b0}}, vaddr[LOW_W-1:0]};
  assign fault     = strb.privFault | (strb.relocate & ~inBounds);

  always_comb begin
    addrFault = fault;
    if (fault) begin
      paddr     = '0;
      cacheAttr = ATTR_UNCACHED;
      badVaddr  = vaddr;
    end else begin
      badVaddr = '0;
      if (strb.relocate)        paddr = relocSum;
      else if (strb.fixedClear) paddr = fixedAddr;
      else                      paddr = vaddr;
      cacheAttr = strb.forceUnc ? ATTR_UNCACHED : fieldArr[region];
    end
  end

endmodule

// File: rtl/bb_xlate_top.sv
`timescale 1ns/1ps
module bb_xlate_top
  import bb_xlate_pkg::*;
#(
  parameter int AW = 32,
  parameter int RB = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [AW-1:0]     vaddr,
  input  logic              accFetch,
  input  logic              kernelMode,
  input  logic              regWrEn,
  input  logic [2:0]        regWrSel,
  input  logic [AW-1:0]     regWrData,
  output logic [AW-1:0]     paddr,
  output logic [ATTR_W-1:0] cacheAttr,
  output logic              addrFault,
  output logic [AW-1:0]     badVaddr
);

  xlateStrb_t strb;

  bb_xlate_ctrl #(.RB(RB)) i_ctrl (
    .region     (vaddr[AW-1 -: RB]),
    .kernelMode (kernelMode),
    .accFetch   (accFetch),
    .regWrEn    (regWrEn),
    .regWrSel   (regWrSel),
    .strb       (strb)
  );

  bb_xlate_datapath #(.AW(AW), .RB(RB)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .vaddr     (vaddr),
    .paddr     (paddr),
    .cacheAttr (cacheAttr),
    .addrFault (addrFault),
    .badVaddr  (badVaddr)
  );

endmodule

// File: rtl/bb_xlate_checker.sv
`timescale 1ns/1ps
module bb_xlate_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] vaddr,
  input logic        accFetch,
  input logic        kernelMode,
  input logic        regWrEn,
  input logic [2:0]  regWrSel,
  input logic [31:0] paddr,
  input logic [2:0]  cacheAttr,
  input logic        addrFault,
  input logic [31:0] badVaddr
);

  a_r5_user_kernel_fault: assert property (@(posedge clk) disable iff (!rstN)
    (!kernelMode && vaddr[31]) |-> addrFault);

  a_r6_fixed_window: assert property (@(posedge clk) disable iff (!rstN)
    (kernelMode && vaddr[31:30] == 2'b10) |-> (!addrFault && paddr == {3'b000, vaddr[28:0]}));

  a_r7_identity_window: assert property (@(posedge clk) disable iff (!rstN)
    (kernelMode && vaddr[31:30] == 2'b11) |-> (!addrFault && paddr == vaddr));

  a_r9_forced_uncached: assert property (@(posedge clk) disable iff (!rstN)
    (vaddr[31:29] == 3'd5) |-> (cacheAttr == 3'd0));

  a_r10_fault_outputs: assert property (@(posedge clk) disable iff (!rstN)
    addrFault |-> (paddr == 32'd0 && cacheAttr == 3'd0 && badVaddr == vaddr));

  a_r10_no_fault_bad: assert property (@(posedge clk) disable iff (!rstN)
    !addrFault |-> (badVaddr == 32'd0));

  a_r11_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrSel > 3'd4) ##1 ($stable(vaddr) && $stable(kernelMode) && $stable(accFetch))
      |-> ($stable(paddr) && $stable(cacheAttr) && $stable(addrFault)));

endmodule

bind bb_xlate_top bb_xlate_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .vaddr      (vaddr),
  .accFetch   (accFetch),
  .kernelMode (kernelMode),
  .regWrEn    (regWrEn),
  .regWrSel   (regWrSel),
  .paddr      (paddr),
  .cacheAttr  (cacheAttr),
  .addrFault  (addrFault),
  .badVaddr   (badVaddr)
);

// File: tb/test_bb_xlate_top.sv
`timescale 1ns/1ps
module test_bb_xlate_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] vaddr = '0;
  logic        accFetch = 1'b0;
  logic        kernelMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] paddr;
  logic [2:0]  cacheAttr;
  logic        addrFault;
  logic [31:0] badVaddr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  bb_xlate_top i_bb_xlate_top (
    .clk(clk), .rstN(rstN), .vaddr(vaddr), .accFetch(accFetch),
    .kernelMode(kernelMode), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .paddr(paddr), .cacheAttr(cacheAttr),
    .addrFault(addrFault), .badVaddr(badVaddr)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        k;
    logic        f;
    logic [31:0] va;
    logic [31:0] pa;
    logic [2:0]  at;
    logic        flt;
  } vec_t;

  // after programming: iBase 0x10000000, iBound 0xFFFF, dBase 0x20000000,
  // dBound 0x10000, attribute fields region r = (r+1) mod 8
  localparam vec_t VECS [15] = '{
    '{4'd2, 1'b0, 1'b1, 32'h0000_1234, 32'h1000_1234, 3'd1, 1'b0}, // R2
    '{4'd4, 1'b0, 1'b1, 32'h0000_FFFF, 32'h1000_FFFF, 3'd1, 1'b0}, // R4 at limit
    '{4'd4, 1'b0, 1'b1, 32'h0001_0000, 32'h0000_0000, 3'd0, 1'b1}, // R4 limit+1
    '{4'd3, 1'b0, 1'b0, 32'h0001_0000, 32'h2001_0000, 3'd1, 1'b0}, // R3 data pair
    '{4'd4, 1'b0, 1'b0, 32'h0001_0001, 32'h0000_0000, 3'd0, 1'b1}, // R4 data limit+1
    '{4'd5, 1'b1, 1'b0, 32'h0000_0040, 32'h2000_0040, 3'd1, 1'b0}, // R5 kernel relocates
    '{4'd5, 1'b1, 1'b1, 32'h0002_0000, 32'h0000_0000, 3'd0, 1'b1}, // R5 kernel limit check
    '{4'd5, 1'b0, 1'b0, 32'h8000_0010, 32'h0000_0000, 3'd0, 1'b1}, // R5 user to kernel
    '{4'd6, 1'b1, 1'b0, 32'h8000_0010, 32'h0000_0010, 3'd5, 1'b0}, // R6
    '{4'd6, 1'b1, 1'b1, 32'h9FFF_FFFC, 32'h1FFF_FFFC, 3'd5, 1'b0}, // R6
    '{4'd9, 1'b1, 1'b0, 32'hA000_0100, 32'h0000_0100, 3'd0, 1'b0}, // R9
    '{4'd9, 1'b1, 1'b0, 32'hBFFF_0000, 32'h1FFF_0000, 3'd0, 1'b0}, // R9
    '{4'd7, 1'b1, 1'b1, 32'hC000_0008, 32'hC000_0008, 3'd7, 1'b0}, // R7
    '{4'd7, 1'b1, 1'b0, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 3'd0, 1'b0}, // R7
    '{4'd5, 1'b0, 1'b1, 32'hE000_0000, 32'h0000_0000, 3'd0, 1'b1}  // R5
  };

  task automatic compareNow(string tag, logic [31:0] va, logic [31:0] ePa,
                            logic [2:0] eAt, logic eF);
    logic [31:0] eBad;
    eBad = eF ? va : 32'd0;  // R10
    nChecks++;
    if (paddr !== ePa || cacheAttr !== eAt || addrFault !== eF || badVaddr !== eBad) begin
      nFails++;
      $display("FAIL %s (R10 bad) va=%h: pa=%h at=%0d flt=%b bad=%h expected pa=%h at=%0d flt=%b bad=%h",
               tag, va, paddr, cacheAttr, addrFault, badVaddr, ePa, eAt, eF, eBad);
    end
  endtask

  task automatic lookup(string tag, logic k, logic f, logic [31:0] va,
                        logic [31:0] ePa, logic [2:0] eAt, logic eF);
    @(negedge clk);
    kernelMode = k; accFetch = f; vaddr = va;
    #2;
    compareNow(tag, va, ePa, eAt, eF);
  endtask

  task automatic regWrite(logic [2:0] sel, logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    lookup("R1", 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 3'd0, 1'b0);
    lookup("R1", 1'b0, 1'b1, 32'h0000_0004, 32'h0000_0000, 3'd0, 1'b1);
    lookup("R1", 1'b1, 1'b0, 32'h8000_0000, 32'h0000_0000, 3'd0, 1'b0);

    // R11 programming through the write port
    regWrite(3'd0, 32'h1000_0000);
    regWrite(3'd1, 32'h0000_FFFF);
    regWrite(3'd2, 32'h2000_0000);
    regWrite(3'd3, 32'h0001_0000);
    regWrite(3'd4, 32'h001F_58D1);

    for (int i = 0; i < 15; i++)
      lookup($sformatf("R%0d", VECS[i].req), VECS[i].k, VECS[i].f, VECS[i].va,
             VECS[i].pa, VECS[i].at, VECS[i].flt);

    // R11 select codes 5..7 are ignored
    regWrite(3'd5, 32'hFFFF_FFFF);
    regWrite(3'd6, 32'hFFFF_FFFF);
    regWrite(3'd7, 32'hFFFF_FFFF);
    lookup("R11", 1'b0, 1'b0, 32'h0001_0001, 32'h0000_0000, 3'd0, 1'b1);
    lookup("R11", 1'b0, 1'b1, 32'h0000_1234, 32'h1000_1234, 3'd1, 1'b0);
    lookup("R11", 1'b1, 1'b0, 32'hC000_0000, 32'hC000_0000, 3'd7, 1'b0);

    // R11 write visible right after the capturing edge
    @(negedge clk);
    kernelMode = 1'b0; accFetch = 1'b0; vaddr = 32'h0002_0000;
    regWrEn = 1'b1; regWrSel = 3'd3; regWrData = 32'h7FFF_FFFF;
    #2;
    compareNow("R11 before edge", vaddr, 32'h0000_0000, 3'd0, 1'b1);
    @(posedge clk); #1;
    compareNow("R11 after edge", vaddr, 32'h2002_0000, 3'd1, 1'b0);
    @(negedge clk);
    regWrEn = 1'b0;

    // R8 attribute fields of regions 1..3
    regWrite(3'd2, 32'h0000_0000);
    lookup("R8", 1'b0, 1'b0, 32'h2000_0000, 32'h2000_0000, 3'd2, 1'b0);
    lookup("R8", 1'b0, 1'b0, 32'h4000_0004, 32'h4000_0004, 3'd3, 1'b0);
    lookup("R8", 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'd4, 1'b0);

    // R2 modulo wrap, R3 pairs stay independent
    regWrite(3'd0, 32'hF000_0000);
    regWrite(3'd1, 32'h7FFF_FFFF);
    lookup("R2", 1'b0, 1'b1, 32'h2000_0000, 32'h1000_0000, 3'd2, 1'b0);
    lookup("R3", 1'b0, 1'b0, 32'h2000_0000, 32'h2000_0000, 3'd2, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule